// File: doc/BRIEF.md
# Parallel Residue-Counter Odd Prime Sieve

This block produces odd candidates 3, 5, 7, ... and screens each one against the fourteen odd primes from 3 to 47 without ever dividing. Each prime owns a small signed counter that tracks the candidate's distance to that prime's next odd multiple. All counters step by two together with the candidate, so a counter reading zero marks a divisor. Only the counters that read zero are reloaded, each with a constant derived from its own prime. Every test therefore costs the same number of cycles, however large the candidate is.

A client raises `next_req` while the block is idle. The block then tests successive candidates. A candidate that any counter rejects is dropped and the following odd number is tested at once. The first candidate that no counter rejects is presented with a one-cycle `valid` pulse, and the block returns to idle. When the next candidate would not fit in the candidate register, the block stops for good and raises `overflow`. Confirming true primality is left to later logic.

The controller is a state machine with seven named states. ST_IDLE waits for a request. ST_ADVANCE steps the candidate and all counters by two, or moves to ST_HALT when the candidate is at its limit. ST_SCAN registers which counters read zero. ST_RELOAD reloads those counters and records the verdict. ST_HOLD pads the test to its fixed length. In ST_REPORT the block goes back to ST_IDLE on a survivor, or returns to ST_ADVANCE on a rejection. ST_HALT is the sticky overflow state and only a reset leaves it.

Top module: `coprime_sieve`

## Requirements
- R1: After reset the candidate is 1, and `busy`, `valid`, `survivor` and `overflow` are all 0.
- R2: Each test first raises the candidate by exactly 2, so the first candidate tested is 3. The candidate changes in no other way.
- R3: A candidate is a survivor exactly when none of 3, 5, 7, 11, 13, 17, 19, 23, 29, 31, 37, 41, 43, 47 divides it. The primes 3 to 47 themselves are therefore rejected and 53 is the first survivor.
- R4: Each test lasts exactly LATENCY cycles (default 7), and a rejected test is followed immediately by the next test. Counted from the clock edge that accepts `next_req`, `valid` is high in cycle 7·k, where k is the number of candidates tested in that request.
- R5: `valid` is high for exactly one cycle per survivor, only together with `survivor` = 1, and the block is idle in the next cycle.
- R6: `survivor` holds the verdict of the most recent test (1 = passed). It updates in the third cycle of each test and keeps its value while idle.
- R7: `next_req` has no effect while `busy` is high, and it is not queued.
- R8: When the candidate plus 2 would exceed 2^CAND_W − 1, the candidate is left unchanged and `overflow` rises and stays high. `busy` stays low and requests are ignored until reset.
- R9: Counters that hit are reloaded with minus twice their prime, and the other counters keep their values. Verdicts therefore stay correct after many hits on the same prime, for example 2021 = 43·47 and 2209 = 47·47 are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| next_req | input | 1 | Request the next survivor; sampled only while idle |
| busy | output | 1 | A search is in progress |
| valid | output | 1 | One-cycle pulse: `cand` is a survivor |
| cand | output | CAND_W | Current candidate value |
| survivor | output | 1 | Verdict of the latest completed test |
| overflow | output | 1 | Candidate range exhausted (sticky) |

## Verification
On every cycle the assertions check four things: `valid` only appears as a single-cycle pulse together with `survivor` and `busy`; every change of the candidate is a step of exactly two; and overflow is sticky, freezes the candidate and keeps the block idle. The divisibility verdicts cannot be seen by a local property, and neither can the reload of the counters, the exact per-test cycle count, or the fact that requests made while busy are dropped. Only the bench's reference model shows these, compared on every clock across a run past 3000. A narrowed candidate width lets the bench reach the overflow stop.

// File: rtl/sieve_pkg.sv
package sieve_pkg;

    localparam int NUM_LANES = 14;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADVANCE,
        ST_SCAN,
        ST_RELOAD,
        ST_HOLD,
        ST_REPORT,
        ST_HALT
    } sieve_state_e;

    // Odd sieve primes in ascending order; lane i screens lane_prime(i).
    function automatic int lane_prime(input int idx);
        case (idx)
            0:       return 3;
            1:       return 5;
            2:       return 7;
            3:       return 11;
            4:       return 13;
            5:       return 17;
            6:       return 19;
            7:       return 23;
            8:       return 29;
            9:       return 31;
            10:      return 37;
            11:      return 41;
            12:      return 43;
            default: return 47;
        endcase
    endfunction

endpackage

// File: rtl/sieve_lane.sv
module sieve_lane #(
    parameter int PRIME = 3,
    parameter int RES_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_en,
    input  logic scan_en,
    input  logic reload_en,
    output logic hit
);
    localparam logic signed [RES_W-1:0] START_V  = RES_W'(-(PRIME - 1));
    localparam logic signed [RES_W-1:0] RELOAD_V = RES_W'(-2 * PRIME);
    localparam logic signed [RES_W-1:0] STEP_V   = RES_W'(2);

    logic signed [RES_W-1:0] res_q;

    // Distance to the next odd multiple of PRIME, kept as a negative count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= START_V;
            hit   <= 1'b0;
        end else begin
            if (step_en) begin
                res_q <= res_q + STEP_V;
            end else if (reload_en && hit) begin
                res_q <= RELOAD_V;
            end
            if (scan_en) begin
                hit <= (res_q == '0);
            end
        end
    end

endmodule

// File: rtl/sieve_cand.sv
module sieve_cand #(
    parameter int CAND_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    output logic [CAND_W-1:0] cand,
    output logic              at_limit
);
    localparam logic [CAND_W-1:0] MAX_V  = '1;
    localparam logic [CAND_W-1:0] STEP_V = CAND_W'(2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand <= CAND_W'(1);
        end else if (step_en) begin
            cand <= cand + STEP_V;
        end
    end

    // The next odd value would not fit.
    assign at_limit = (cand > (MAX_V - STEP_V));

endmodule

// File: rtl/coprime_sieve.sv
module coprime_sieve
    import sieve_pkg::*;
#(
    parameter int CAND_W  = 24,
    parameter int RES_W   = 8,
    parameter int LATENCY = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              next_req,
    output logic              busy,
    output logic              valid,
    output logic [CAND_W-1:0] cand,
    output logic              survivor,
    output logic              overflow
);
    // ADVANCE, SCAN, RELOAD and REPORT take one cycle each; HOLD pads the rest.
    localparam int HOLD_CYC = LATENCY - 4;
    localparam int HCW      = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

    sieve_state_e state_q, state_d;
    logic [HCW-1:0]       hold_cnt;
    logic [NUM_LANES-1:0] hit_vec;
    logic                 surv_q;
    logic                 at_limit;
    logic                 step_en;
    logic                 scan_en;
    logic                 reload_en;

    sieve_cand #(.CAND_W(CAND_W)) u_cand (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .cand     (cand),
        .at_limit (at_limit)
    );

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        sieve_lane #(
            .PRIME (lane_prime(i)),
            .RES_W (RES_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .step_en   (step_en),
            .scan_en   (scan_en),
            .reload_en (reload_en),
            .hit       (hit_vec[i])
        );
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Hold counter and verdict register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt <= '0;
            surv_q   <= 1'b0;
        end else begin
            if (state_q == ST_HOLD) begin
                hold_cnt <= hold_cnt + HCW'(1);
            end else begin
                hold_cnt <= '0;
            end
            if (state_q == ST_RELOAD) begin
                surv_q <= ~|hit_vec;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (next_req) state_d = ST_ADVANCE;
            ST_ADVANCE: state_d = at_limit ? ST_HALT : ST_SCAN;
            ST_SCAN:    state_d = ST_RELOAD;
            ST_RELOAD:  state_d = ST_HOLD;
            ST_HOLD:    if (hold_cnt == HCW'(HOLD_CYC - 1)) state_d = ST_REPORT;
            ST_REPORT:  state_d = surv_q ? ST_IDLE : ST_ADVANCE;
            ST_HALT:    state_d = ST_HALT;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs and lane controls
    always_comb begin
        step_en   = (state_q == ST_ADVANCE) && !at_limit;
        scan_en   = (state_q == ST_SCAN);
        reload_en = (state_q == ST_RELOAD);
        busy      = (state_q != ST_IDLE) && (state_q != ST_HALT);
        valid     = (state_q == ST_REPORT) && surv_q;
        overflow  = (state_q == ST_HALT);
        survivor  = surv_q;
    end

endmodule

// File: rtl/sieve_checker.sv
module sieve_checker #(
    parameter int CAND_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              valid,
    input logic [CAND_W-1:0] cand,
    input logic              survivor,
    input logic              overflow
);
    // R5: a report carries a passing verdict during an active search
    assert_valid_survivor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (survivor && busy));

    // R5: the report lasts one cycle
    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R2: the candidate only ever moves up by two
    assert_cand_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cand) |-> (cand == $past(cand) + CAND_W'(2)));

    // R8: overflow is sticky and freezes the candidate
    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> (overflow && $stable(cand)));

    // R8: an exhausted block is idle and silent
    assert_halt_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (!busy && !valid));

endmodule

bind coprime_sieve sieve_checker #(.CAND_W(CAND_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .valid    (valid),
    .cand     (cand),
    .survivor (survivor),
    .overflow (overflow)
);

// File: tb/tb_coprime_sieve.sv
`timescale 1ns/1ps
module tb_coprime_sieve;
    localparam int CW   = 24;
    localparam int CW_S = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic next_req = 1'b0;
    logic req_s = 1'b0;
    logic busy, valid, survivor, overflow;
    logic [CW-1:0] cand;
    logic busy_s, valid_s, surv_s, ovf_s;
    logic [CW_S-1:0] cand_s;

    always #5 clk = ~clk;

    coprime_sieve #(.CAND_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .next_req(next_req), .busy(busy), .valid(valid),
        .cand(cand), .survivor(survivor), .overflow(overflow)
    );

    coprime_sieve #(.CAND_W(CW_S)) dut_small (
        .clk(clk), .rst_n(rst_n), .next_req(req_s), .busy(busy_s), .valid(valid_s),
        .cand(cand_s), .survivor(surv_s), .overflow(ovf_s)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    function automatic bit is_surv(input longint v);
        for (int d = 3; d <= 47; d += 2) begin
            if (v % d == 0) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Behavioural reference: search state, test phase, candidate, verdict.
    bit     m_busy, m_valid, m_surv, m_ovf;
    int     m_phase;
    longint m_cand;
    localparam longint MAXV = (longint'(1) << CW) - 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_valid = 0; m_surv = 0; m_ovf = 0; m_phase = 0; m_cand = 1;
        end else begin
            if (!m_busy) begin
                if (next_req && !m_ovf) begin m_busy = 1; m_phase = 0; end
            end else begin
                case (m_phase)
                    0: if (m_cand + 2 > MAXV) begin m_ovf = 1; m_busy = 0; end
                       else begin m_cand += 2; m_phase = 1; end
                    2: begin m_surv = is_surv(m_cand); m_phase = 3; end
                    6: if (m_surv) m_busy = 0; else m_phase = 0;
                    default: m_phase++;
                endcase
            end
        end
        m_valid = m_busy && (m_phase == 6) && m_surv;
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cand == m_cand[CW-1:0], "R2 cand", cand, m_cand);
            chk(valid == m_valid, "R4 valid", valid, m_valid);
            chk(survivor == m_surv, "R6 survivor", survivor, m_surv);
            chk(busy == m_busy, "R7 busy", busy, m_busy);
            chk(overflow == m_ovf, "R8 overflow", overflow, m_ovf);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            chk(1'b0, "watchdog", cyc, 190000);
            finish_up();
        end
    end

    task automatic hunt(input bit inject, output int lat);
        while (busy) @(negedge clk);
        next_req = 1'b1;
        @(negedge clk);
        next_req = 1'b0;
        lat = 1;
        while (!valid && !overflow && lat < 100000) begin
            next_req = inject && (lat == 3);
            @(negedge clk);
            next_req = 1'b0;
            lat++;
        end
    endtask

    task automatic hunt_s(output bit got);
        while (busy_s) @(negedge clk);
        req_s = 1'b1;
        @(negedge clk);
        req_s = 1'b0;
        while (!valid_s && !ovf_s) @(negedge clk);
        got = valid_s;
    endtask

    initial begin
        longint prev, exp_c;
        int lat, n_surv_s;
        bit got, seen_bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cand == 1, "R1 cand", cand, 1);
        chk(!busy && !valid && !survivor && !overflow, "R1 flags",
            {busy, valid, survivor, overflow}, 0);

        // R2/R6: first test, candidate 3, verdict known in cycle 3
        next_req = 1'b1;
        @(negedge clk);
        next_req = 1'b0;
        @(negedge clk);
        chk(cand == 3, "R2 first candidate", cand, 3);
        @(negedge clk);
        @(negedge clk);
        chk(survivor == 0, "R6 verdict for 3", survivor, 0);
        while (!valid) @(negedge clk);
        chk(cand == 53, "R3 first survivor", cand, 53);
        @(negedge clk);
        chk(!valid && !busy, "R5 single pulse then idle", {valid, busy}, 0);
        chk(survivor == 1, "R6 verdict held while idle", survivor, 1);

        // R3/R4/R7/R9: survivor search up to 3000
        prev = 53;
        seen_bad = 1'b0;
        while (prev < 3000) begin
            exp_c = prev + 2;
            while (!is_surv(exp_c)) exp_c += 2;
            hunt(prev == 101, lat);
            chk(valid && cand == exp_c[CW-1:0], "R3 next survivor", cand, exp_c);
            chk(lat == 7 * int'((exp_c - prev) / 2), "R4 test latency", lat,
                7 * ((exp_c - prev) / 2));
            if (cand == 2021 || cand == 2209) seen_bad = 1'b1;
            if (prev == 101) begin
                repeat (10) @(negedge clk);
                chk(!busy, "R7 request during busy not queued", busy, 0);
            end
            prev = exp_c;
        end
        chk(!seen_bad, "R9 repeated multiples rejected", seen_bad, 0);

        // R8: narrow instance runs out of range
        n_surv_s = 0;
        got = 1'b1;
        while (!ovf_s) begin
            hunt_s(got);
            if (got) begin
                n_surv_s++;
                prev = cand_s;
            end
        end
        chk(n_surv_s == 39, "R3 survivor count below 256", n_surv_s, 39);
        chk(prev == 251, "R3 last survivor below 256", prev, 251);
        chk(cand_s == 255, "R8 candidate held at limit", cand_s, 255);
        req_s = 1'b1;
        @(negedge clk);
        req_s = 1'b0;
        repeat (3) @(negedge clk);
        chk(ovf_s && !busy_s && cand_s == 255, "R8 sticky and ignores requests",
            {ovf_s, busy_s}, 2);
        finish_up();
    end

endmodule